// File: doc/BRIEF.md
# Packet Fetch and Dispatch Front End

This block is the front end of a wide-issue processor core. It streams fetch packets of eight 32-bit instructions (256 bits each) out of a program memory. A packet address moves through four fetch phases: generate, send, wait and read. The packet then moves through two decode-side phases, dispatch and unit decode. In steady state one packet enters and one leaves every clock cycle. The core's execute logic sees a new packet with its address on the output each cycle.

Branches come from the execute side on a redirect input. The redirect input is sampled on the cycle the branch enters its first execute phase, and the front end loads the target five cycles later. Nothing is flushed: every packet already fetched keeps flowing as a delay slot, and software schedules around the hazards. While any redirect is still pending, an interrupt-enable output is held low. If the memory is slow, only the wait phase and the phases ahead of it stall. The read, dispatch and decode phases keep draining.

Top module: `fetch_frontend`

## Requirements
- R1: While reset is high, and in the first cycle after it, pkt_valid and mem_req_valid are 0 and irq_enable is 1. One clock edge after reset is released, mem_req_valid is 1 and mem_req_addr equals RESET_ADDR.
- R2: Each request address is the previous one plus 32. Bits [4:0] of every request and output address are 0, and a redirect target is loaded with bits [4:0] cleared.
- R3: pkt_data is the 256-bit word the memory returned for pkt_addr. Lane i (bits 32i+31 down to 32i) holds the instruction at pkt_addr+4i.
- R4: With mem_rsp_ready held high, the first packet (RESET_ADDR) appears on the output after the 5th clock edge following reset release. After that, one packet is output every cycle, in address order.
- R5: A redirect sampled at edge t becomes the fetch address at edge t+5, and the target packet is output after edge t+10. Every packet fetched before the target is still output in order, with none dropped.
- R6: irq_enable is low in the five cycles after each edge that samples a redirect, and high otherwise.
- R7: While a request waits and mem_rsp_ready is low, mem_req_addr holds its value and the read, dispatch and decode phases keep draining, so pkt_valid falls within three edges. After the memory responds, the packet stream continues with no packet lost or repeated.
- R8: Two redirects sampled three cycles apart each take effect at their own time, in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | A branch enters its first execute phase this cycle |
| redir_target | input | AW | Branch target byte address |
| mem_req_valid | output | 1 | Request to program memory is presented |
| mem_req_addr | output | AW | Packet address sent to program memory |
| mem_rsp_data | input | IW*NI | Packet returned by memory for the waiting request |
| mem_rsp_ready | input | 1 | Response data is valid for the waiting request |
| pkt_valid | output | 1 | Decoded packet is valid |
| pkt_addr | output | AW | Address of the decoded packet |
| pkt_data | output | IW*NI | Decoded packet, eight instruction lanes |
| irq_enable | output | 1 | Low while any redirect is pending |

## Verification
The hardest case to reach is a redirect whose five-cycle countdown ends while the wait phase is stalled on a slow memory. In that case the fetch address changes while the request ahead of it is frozen, and the target must still arrive exactly once, after the pending delay slots. The bench reaches this case by combining redirects with repeating patterns of low memory ready. Its memory model tracks its own single outstanding request. For those runs the output stream is checked as a sequence, because the exact cycles depend on the stall pattern; runs with the memory always ready are checked cycle by cycle.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int FE_ADDR_W     = 32;
  localparam int FE_INSN_W     = 32;
  localparam int FE_PKT_INSNS  = 8;
  localparam int FE_BR_DELAY   = 5;
  localparam int FE_DEC_PHASES = 2;
endpackage

// File: rtl/fe_redirect_line.sv
// Carries pending branch targets for a fixed number of cycles, then fires.
module fe_redirect_line #(
  parameter int AW    = fe_pkg::FE_ADDR_W,
  parameter int DEPTH = fe_pkg::FE_BR_DELAY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [AW-1:0] in_tgt,
  output logic          fire,
  output logic [AW-1:0] fire_tgt,
  output logic          busy
);
  logic [DEPTH-1:0] slot_v;
  logic [AW-1:0]    slot_t [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v <= '0;
    end else begin
      for (int i = DEPTH-1; i > 0; i--) slot_v[i] <= slot_v[i-1];
      slot_v[0] <= in_v;
    end
    for (int i = DEPTH-1; i > 0; i--) slot_t[i] <= slot_t[i-1];
    slot_t[0] <= in_tgt;
  end

  assign fire     = slot_v[DEPTH-1];
  assign fire_tgt = slot_t[DEPTH-1];
  assign busy     = |slot_v;

  // R6: a sampled redirect is pending in the next cycle
  assert_pending_R6: assert property (@(posedge clk) disable iff (rst)
    in_v |=> busy);
  // R5: a firing slot was pending one cycle earlier
  assert_fire_origin_R5: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(busy));
endmodule

// File: rtl/fe_fetch_phases.sv
// Generate, send, wait and read phases of packet fetch.
module fe_fetch_phases #(
  parameter int          AW   = fe_pkg::FE_ADDR_W,
  parameter int          PW   = fe_pkg::FE_INSN_W * fe_pkg::FE_PKT_INSNS,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int         OFS  = $clog2(PW/8),
  localparam logic [AW-1:0] STEP = AW'(PW/8),
  localparam logic [AW-1:0] ALIGN = ~AW'((1 << OFS) - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [AW-1:0] fire_tgt,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic [PW-1:0] mem_rsp_data,
  input  logic          mem_rsp_ready,
  output logic          rd_v,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_data
);
  logic [AW-1:0] gen_pc;
  logic          snd_v, wt_v;
  logic [AW-1:0] snd_addr, wt_addr;
  logic          hold;

  assign hold = wt_v & ~mem_rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_pc <= RESET_ADDR & ALIGN;
      snd_v  <= 1'b0;
      wt_v   <= 1'b0;
      rd_v   <= 1'b0;
    end else begin
      if (fire)       gen_pc <= fire_tgt & ALIGN;
      else if (!hold) gen_pc <= gen_pc + STEP;
      if (!hold) begin
        snd_v <= 1'b1;
        wt_v  <= snd_v;
      end
      rd_v <= wt_v & mem_rsp_ready;
    end
    if (!hold) begin
      snd_addr <= gen_pc;
      wt_addr  <= snd_addr;
    end
    if (wt_v && mem_rsp_ready) begin
      rd_addr <= wt_addr;
      rd_data <= mem_rsp_data;
    end
  end

  assign mem_req_valid = snd_v;
  assign mem_req_addr  = snd_addr;

  // R2: requests are packet aligned
  assert_req_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFS-1:0] == '0));
  // R7: a waiting request with memory not ready keeps the sent address
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && wt_v && !mem_rsp_ready) |=> $stable(mem_req_addr));
  // R7: the read phase empties when the wait phase stalls
  assert_read_drain_R7: assert property (@(posedge clk) disable iff (rst)
    (wt_v && !mem_rsp_ready) |=> !rd_v);
  // R5: the generate phase takes the redirect target when it fires
  assert_redirect_load_R5: assert property (@(posedge clk) disable iff (rst)
    fire |=> (gen_pc == ($past(fire_tgt) & ALIGN)));
endmodule

// File: rtl/fe_pipe_phase.sv
// One dispatch-side phase register.
module fe_pipe_phase #(
  parameter int AW = fe_pkg::FE_ADDR_W,
  parameter int PW = fe_pkg::FE_INSN_W * fe_pkg::FE_PKT_INSNS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [AW-1:0] in_addr,
  input  logic [PW-1:0] in_data,
  output logic          out_v,
  output logic [AW-1:0] out_addr,
  output logic [PW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_v;
    if (in_v) begin
      out_addr <= in_addr;
      out_data <= in_data;
    end
  end

  // R4: phases never stall, a valid packet moves on every cycle
  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    in_v |=> (out_v && out_addr == $past(in_addr)));
endmodule

// File: rtl/fetch_frontend.sv
module fetch_frontend #(
  parameter int AW         = fe_pkg::FE_ADDR_W,
  parameter int IW         = fe_pkg::FE_INSN_W,
  parameter int NI         = fe_pkg::FE_PKT_INSNS,
  parameter int BR_DLY     = fe_pkg::FE_BR_DELAY,
  parameter int DEC_PHASES = fe_pkg::FE_DEC_PHASES,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int PW  = IW * NI,
  localparam int OFS = $clog2(PW/8)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_target,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic [PW-1:0] mem_rsp_data,
  input  logic          mem_rsp_ready,
  output logic          pkt_valid,
  output logic [AW-1:0] pkt_addr,
  output logic [PW-1:0] pkt_data,
  output logic          irq_enable
);
  logic          fire, pend;
  logic [AW-1:0] fire_tgt;
  logic          ph_v    [DEC_PHASES+1];
  logic [AW-1:0] ph_addr [DEC_PHASES+1];
  logic [PW-1:0] ph_data [DEC_PHASES+1];

  fe_redirect_line #(.AW(AW), .DEPTH(BR_DLY)) i_redirect (
    .clk(clk), .rst(rst), .in_v(redir_valid), .in_tgt(redir_target),
    .fire(fire), .fire_tgt(fire_tgt), .busy(pend));

  fe_fetch_phases #(.AW(AW), .PW(PW), .RESET_ADDR(RESET_ADDR)) i_fetch (
    .clk(clk), .rst(rst), .fire(fire), .fire_tgt(fire_tgt),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_ready(mem_rsp_ready),
    .rd_v(ph_v[0]), .rd_addr(ph_addr[0]), .rd_data(ph_data[0]));

  for (genvar g = 0; g < DEC_PHASES; g++) begin : g_dec
    fe_pipe_phase #(.AW(AW), .PW(PW)) i_phase (
      .clk(clk), .rst(rst),
      .in_v(ph_v[g]), .in_addr(ph_addr[g]), .in_data(ph_data[g]),
      .out_v(ph_v[g+1]), .out_addr(ph_addr[g+1]), .out_data(ph_data[g+1]));
  end

  assign pkt_valid  = ph_v[DEC_PHASES];
  assign pkt_addr   = ph_addr[DEC_PHASES];
  assign pkt_data   = ph_data[DEC_PHASES];
  assign irq_enable = ~pend;

  // R6: interrupts blocked the cycle after a redirect is sampled
  assert_irq_block_R6: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !irq_enable);
  // R2: output packets are aligned
  assert_out_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_addr[OFS-1:0] == '0));
endmodule

// File: tb/test_fetch_frontend.sv
module test_fetch_frontend;
  localparam int AW = 32, IW = 32, NI = 8, PW = IW*NI;
  localparam logic [31:0] A0 = 32'h0000_0100;
  localparam int NCYC = 40;
  localparam int NVEC = 6;
  // {first redirect edge, second redirect edge, target, ready mask}
  localparam logic [63:0] VEC [NVEC] = '{
    {8'd0,  8'd0, 32'h0000_0000, 16'hFFFF},
    {8'd8,  8'd0, 32'h0000_1000, 16'hFFFF},
    {8'd6,  8'd9, 32'h0000_2000, 16'hFFFF},
    {8'd12, 8'd0, 32'h0000_3013, 16'hFFFF},
    {8'd0,  8'd0, 32'h0000_0000, 16'hF7B5},
    {8'd10, 8'd0, 32'h0000_4000, 16'h0F0F}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, redir_valid, mem_req_valid, mem_rsp_ready, pkt_valid, irq_enable;
  logic [AW-1:0] redir_target, mem_req_addr, pkt_addr;
  logic [PW-1:0] mem_rsp_data, pkt_data;

  fetch_frontend #(.RESET_ADDR(A0)) i_fetch_frontend (
    .clk(clk), .rst(rst), .redir_valid(redir_valid), .redir_target(redir_target),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_ready(mem_rsp_ready),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .irq_enable(irq_enable));

  int checks = 0, fails = 0;
  logic [31:0] exp_pc [NCYC+1];

  // memory model with one outstanding request
  logic        m_busy;
  logic [31:0] m_addr;
  always @(posedge clk) begin
    if (rst) m_busy <= 1'b0;
    else begin
      if (m_busy && mem_rsp_ready) m_busy <= 1'b0;
      if (mem_req_valid && (!m_busy || mem_rsp_ready)) begin
        m_busy <= 1'b1;
        m_addr <= mem_req_addr;
      end
    end
  end

  function automatic logic [PW-1:0] pkt_of(input logic [31:0] a);
    logic [PW-1:0] p;
    for (int i = 0; i < NI; i++) p[i*32 +: 32] = (a + 32'(4*i)) ^ 32'hF00D_0000;
    return p;
  endfunction

  assign mem_rsp_data = m_busy ? pkt_of(m_addr) : '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; redir_valid = 1'b0; redir_target = '0; mem_rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // ---------------- vector table ----------------
    for (int v = 0; v < NVEC; v++) begin
      int t1, t2;
      logic [31:0] tgt1, tgt2, last;
      logic [15:0] mask;
      bit exact, jumped;
      string tag;
      t1 = int'(VEC[v][63:56]); t2 = int'(VEC[v][55:48]);
      tgt1 = VEC[v][47:16]; tgt2 = tgt1 + 32'h400; mask = VEC[v][15:0];
      exact = (mask == 16'hFFFF);
      tag = (t2 != 0) ? "R8" : (t1 != 0) ? "R5" : "R4";
      exp_pc[0] = A0;
      for (int j = 1; j <= NCYC; j++) begin
        if (t1 != 0 && j == t1 + 5)      exp_pc[j] = tgt1 & ~32'h1F;
        else if (t2 != 0 && j == t2 + 5) exp_pc[j] = tgt2 & ~32'h1F;
        else                             exp_pc[j] = exp_pc[j-1] + 32'd32;
      end
      do_reset();
      last = A0 - 32'd32; jumped = 1'b0;
      for (int k = 1; k <= NCYC; k++) begin
        bit hold, exp_irq;
        logic [31:0] prev;
        redir_valid = (t1 != 0 && k == t1) || (t2 != 0 && k == t2);
        redir_target = (k == t2) ? tgt2 : tgt1;
        mem_rsp_ready = mask[k % 16];
        hold = m_busy && !mem_rsp_ready;
        prev = mem_req_addr;
        step();
        redir_valid = 1'b0;
        exp_irq = !((t1 != 0 && k >= t1 && k <= t1 + 4) || (t2 != 0 && k >= t2 && k <= t2 + 4));
        chk(irq_enable == exp_irq, "R6 irq_enable", 64'(irq_enable), 64'(exp_irq));
        if (hold) chk(mem_req_addr == prev, "R7 request hold", 64'(mem_req_addr), 64'(prev));
        if (exact) begin
          if (k >= 5) begin
            chk(pkt_valid == 1'b1, {tag, " valid"}, 64'(pkt_valid), 64'd1);
            chk(pkt_addr == exp_pc[k-5], {tag, " addr"}, 64'(pkt_addr), 64'(exp_pc[k-5]));
          end else begin
            chk(pkt_valid == 1'b0, "R4 pipeline fill", 64'(pkt_valid), 64'd0);
          end
        end
        if (pkt_valid) begin
          chk(pkt_data == pkt_of(pkt_addr), "R3 data", 64'(pkt_data[63:0]), 64'(pkt_of(pkt_addr)));
          chk(pkt_addr[4:0] == 5'd0, "R2 alignment", 64'(pkt_addr), 64'(pkt_addr & ~32'h1F));
          if (!exact) begin
            if (t1 != 0 && !jumped && pkt_addr == (tgt1 & ~32'h1F)) jumped = 1'b1;
            else chk(pkt_addr == last + 32'd32, "R7 stream order", 64'(pkt_addr), 64'(last + 32'd32));
            last = pkt_addr;
          end
        end
      end
      if (!exact && t1 != 0) chk(jumped, "R5 target reached under stall", 64'(jumped), 64'd1);
    end

    // ---------------- directed: reset state (R1) ----------------
    do_reset();
    chk(pkt_valid == 1'b0, "R1 pkt_valid after reset", 64'(pkt_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 req_valid after reset", 64'(mem_req_valid), 64'd0);
    chk(irq_enable == 1'b1, "R1 irq_enable after reset", 64'(irq_enable), 64'd1);
    step();
    chk(mem_req_valid == 1'b1, "R1 first request", 64'(mem_req_valid), 64'd1);
    chk(mem_req_addr == A0, "R1 first address", 64'(mem_req_addr), 64'(A0));
    // reset in the middle of a redirect
    repeat (6) step();
    redir_valid = 1'b1; redir_target = 32'h8000;
    step();
    redir_valid = 1'b0; rst = 1'b1;
    step();
    chk(pkt_valid == 1'b0, "R1 mid-run reset valid", 64'(pkt_valid), 64'd0);
    chk(irq_enable == 1'b1, "R1 mid-run reset irq", 64'(irq_enable), 64'd1);
    rst = 1'b0;

    // ---------------- directed: long stall drains (R7) ----------------
    do_reset();
    begin
      logic [31:0] last_out, held;
      bit found;
      repeat (8) step();
      last_out = pkt_addr;
      mem_rsp_ready = 1'b0;
      step();
      last_out = pkt_valid ? pkt_addr : last_out;
      held = mem_req_addr;
      step();
      last_out = pkt_valid ? pkt_addr : last_out;
      step();
      chk(pkt_valid == 1'b0, "R7 drained after stall", 64'(pkt_valid), 64'd0);
      step(); step();
      chk(mem_req_addr == held, "R7 address held in long stall", 64'(mem_req_addr), 64'(held));
      mem_rsp_ready = 1'b1;
      found = 1'b0;
      for (int i = 0; i < 6 && !found; i++) begin
        step();
        if (pkt_valid) begin
          found = 1'b1;
          chk(pkt_addr == last_out + 32'd32, "R7 resume order", 64'(pkt_addr), 64'(last_out + 32'd32));
        end
      end
      chk(found, "R7 stream resumes", 64'(found), 64'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule